// File: doc/BRIEF.md
# Twin-Predicated Vector Element Stepper

This block sequences one vector element operation in which the source element stream and the destination element stream each have their own predicate mask. It keeps two cursors over a vector of length VL. The source cursor steps only through source elements whose mask bit is set. The destination cursor steps only through destination slots whose mask bit is set. On each step the block pairs the next active source element with the next active destination slot. It reads the source register, sign-extends its low byte to 64 bits, and writes the result to the paired destination register. One pass therefore packs the active source elements together and spreads them out again into the active destination slots.

A start strobe latches VL, the two masks with their inversion flags, and the base register numbers of the two operands. The block reads the element register file through a combinational read port. It issues at most one write per clock, then pulses done. Elements are consecutive registers from a base number, and register numbers wrap inside a 32-entry file.

Top module: `twin_pred_stepper`

## Requirements
- R1: After reset, wr_en, done and busy are 0.
- R2: A start pulse while idle latches both masks. The effective mask of each stream is its input mask, complemented bit by bit when that stream's invert flag is 1. busy goes to 1 on the edge that samples start.
- R3: The k-th set bit of the effective source mask, counted upward from bit 0, is paired with the k-th set bit of the effective destination mask.
- R4: The written value is bits [7:0] of the source register, sign-extended to 64 bits. Bit 7 is copied into bits [63:8].
- R5: Element i of the source is register (src_base + i) mod 32. Element j of the destination is register (dst_base + j) mod 32.
- R6: A destination slot whose effective mask bit is 0 is never written and keeps its prior contents.
- R7: The run ends when either stream has no active element left. Unused active elements of the other stream are never read or written.
- R8: Mask bits at positions greater than or equal to VL are ignored. VL = 0 produces no writes.
- R9: Writes appear on consecutive cycles. The first write is visible in the cycle after the edge that follows the start edge, so a run with P pairs writes exactly P times.
- R10: done is a one-cycle pulse. It is visible P+1 cycles after the start edge, directly after the last write, and busy falls at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a pass (accepted while idle) |
| vl | input | 7 | Vector length, 0 to 64 |
| src_mask | input | 64 | Source predicate mask |
| src_inv | input | 1 | Use the complement of src_mask |
| dst_mask | input | 64 | Destination predicate mask |
| dst_inv | input | 1 | Use the complement of dst_mask |
| src_base | input | 5 | First register of the source vector |
| dst_base | input | 5 | First register of the destination vector |
| rd_addr | output | 5 | Register file read address |
| rd_data | input | 64 | Register file read data (same cycle) |
| wr_en | output | 1 | Register file write enable |
| wr_addr | output | 5 | Register file write address |
| wr_data | output | 64 | Register file write data |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |

## Verification
The hardest condition to reach from the ports is the point where the two cursors move apart. This happens when a source element is consumed while the destination cursor jumps over several cleared slots, and when one stream runs dry while the other still has active bits. The directed cases reach it with masks whose set bits sit at different positions and in different numbers. Examples are a sparse source against a dense destination, a dense source against a single destination slot, and masks that are all ones above VL. Register windows that cross register 31 and overlap each other force the pairing order and the address wrap to show up in the final register contents.

// File: rtl/tp_pkg.sv
package tp_pkg;
    localparam int XLEN   = 64;
    localparam int NREG   = 32;
    localparam int REGW   = $clog2(NREG);
    localparam int VLW    = $clog2(XLEN + 1);
    localparam int IDXW   = $clog2(XLEN);
    localparam int BYTE_W = 8;

    typedef logic [XLEN-1:0] elem_t;
    typedef logic [REGW-1:0] regnum_t;
endpackage

// File: rtl/tp_lowest_set.sv
module tp_lowest_set #(
    parameter int W  = 64,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
    assign found = |vec;
endmodule

// File: rtl/tp_sext.sv
module tp_sext #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 64
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);
    assign dout = {{(OUT_W - IN_W){din[IN_W-1]}}, din};
endmodule

// File: rtl/twin_pred_stepper.sv
module twin_pred_stepper
    import tp_pkg::*;
#(
    parameter int EW  = XLEN,
    parameter int NR  = NREG,
    parameter int OPW = BYTE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [$clog2(EW+1)-1:0] vl,
    input  logic [EW-1:0]           src_mask,
    input  logic                    src_inv,
    input  logic [EW-1:0]           dst_mask,
    input  logic                    dst_inv,
    input  logic [$clog2(NR)-1:0]   src_base,
    input  logic [$clog2(NR)-1:0]   dst_base,
    output logic [$clog2(NR)-1:0]   rd_addr,
    input  logic [EW-1:0]           rd_data,
    output logic                    wr_en,
    output logic [$clog2(NR)-1:0]   wr_addr,
    output logic [EW-1:0]           wr_data,
    output logic                    busy,
    output logic                    done
);
    localparam int LVW = $clog2(EW + 1);
    localparam int LIW = $clog2(EW);
    localparam int LRW = $clog2(NR);

    typedef struct packed {
        logic           busy;
        logic [EW-1:0]  src_m;
        logic [EW-1:0]  dst_m;
        logic [LRW-1:0] src_base;
        logic [LRW-1:0] dst_base;
        logic [LVW-1:0] vl;
        logic           wr_en;
        logic [LRW-1:0] wr_addr;
        logic [EW-1:0]  wr_data;
        logic           done;
    } state_t;

    state_t st_d, st_q;

    // VL window: bits at or beyond VL never become active
    logic [EW-1:0] vl_win;
    always_comb begin
        for (int i = 0; i < EW; i++) begin
            vl_win[i] = (LVW'(i) < vl);
        end
    end

    // next active element of each stream
    logic           s_found, d_found;
    logic [LIW-1:0] s_idx, d_idx;

    tp_lowest_set #(.W(EW), .IW(LIW)) u_src_pick (
        .vec(st_q.src_m), .found(s_found), .idx(s_idx)
    );
    tp_lowest_set #(.W(EW), .IW(LIW)) u_dst_pick (
        .vec(st_q.dst_m), .found(d_found), .idx(d_idx)
    );

    logic [EW-1:0] ext_val;
    tp_sext #(.IN_W(OPW), .OUT_W(EW)) u_ext (
        .din(rd_data[OPW-1:0]), .dout(ext_val)
    );

    logic pair_ok;
    assign pair_ok = st_q.busy && s_found && d_found;
    assign rd_addr = st_q.src_base + LRW'(s_idx);

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        st_d.done  = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy     = 1'b1;
                st_d.src_m    = (src_mask ^ {EW{src_inv}}) & vl_win;
                st_d.dst_m    = (dst_mask ^ {EW{dst_inv}}) & vl_win;
                st_d.src_base = src_base;
                st_d.dst_base = dst_base;
                st_d.vl       = vl;
            end
        end else if (pair_ok) begin
            st_d.wr_en   = 1'b1;
            st_d.wr_addr = st_q.dst_base + LRW'(d_idx);
            st_d.wr_data = ext_val;
            st_d.src_m   = st_q.src_m & (st_q.src_m - 1'b1);
            st_d.dst_m   = st_q.dst_m & (st_q.dst_m - 1'b1);
        end else begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en   = st_q.wr_en;
    assign wr_addr = st_q.wr_addr;
    assign wr_data = st_q.wr_data;
    assign busy    = st_q.busy;
    assign done    = st_q.done;

    // R10: done lasts exactly one cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: every write comes from a cycle that was busy
    a_r9_write_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(busy));
    // R10: done never coincides with a write
    a_r10_done_after_writes: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && done));
    // R8: a pair is only formed from positions below the latched VL
    a_r8_pair_below_vl: assert property (@(posedge clk) disable iff (!rst_n)
        pair_ok |-> (LVW'(s_idx) < st_q.vl && LVW'(d_idx) < st_q.vl));
    // R2: a run begins only from a start request
    a_r2_start_begins: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    // R10: busy falls together with the done pulse
    a_r10_busy_falls: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

// File: tb/twin_pred_stepper_bench.sv
module twin_pred_stepper_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  vl = '0;
    logic [63:0] src_mask = '0, dst_mask = '0;
    logic        src_inv = 1'b0, dst_inv = 1'b0;
    logic [4:0]  src_base = '0, dst_base = '0;
    logic [4:0]  rd_addr, wr_addr;
    logic [63:0] rd_data, wr_data;
    logic        wr_en, busy, done;

    logic [63:0] rf [32];
    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    assign rd_data = rf[rd_addr];
    always @(posedge clk) if (wr_en) rf[wr_addr] <= wr_data;

    twin_pred_stepper u_twin_pred_stepper (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
        .src_mask(src_mask), .src_inv(src_inv),
        .dst_mask(dst_mask), .dst_inv(dst_inv),
        .src_base(src_base), .dst_base(dst_base),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] sx8(input logic [63:0] v);
        return {{56{v[7]}}, v[7:0]};
    endfunction

    task automatic fill_rf(input logic [63:0] seed);
        for (int i = 0; i < 32; i++) rf[i] = seed ^ (64'(i) * 64'h9E37_79B9_7F4A_7C15);
    endtask

    // run one pass and compare against an independent compress/expand model
    task automatic run_case(input string req, input int n_vl,
                            input logic [63:0] sm, input logic si,
                            input logic [63:0] dm, input logic di,
                            input logic [4:0] sb, input logic [4:0] db);
        logic [63:0] exp_rf [32];
        logic [63:0] es, ed;
        int sl [64];
        int dl [64];
        int ns = 0, nd = 0, np, nwr = 0, done_at = -1;
        bit order_ok = 1'b1;
        es = si ? ~sm : sm;
        ed = di ? ~dm : dm;
        for (int i = 0; i < 32; i++) exp_rf[i] = rf[i];
        for (int i = 0; i < n_vl; i++) begin
            if (es[i]) begin sl[ns] = i; ns++; end
            if (ed[i]) begin dl[nd] = i; nd++; end
        end
        np = (ns < nd) ? ns : nd;
        for (int k = 0; k < np; k++)
            exp_rf[(32'(db) + dl[k]) % 32] = sx8(exp_rf[(32'(sb) + sl[k]) % 32]);

        @(negedge clk);
        vl = 7'(n_vl); src_mask = sm; src_inv = si; dst_mask = dm; dst_inv = di;
        src_base = sb; dst_base = db; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2", {req, " busy after start"}, 64'(busy), 64'd1);
        for (int n = 1; n <= 200; n++) begin
            @(negedge clk);
            if (wr_en) begin
                nwr++;
                if (n > np) order_ok = 1'b0;
            end else if (n <= np) order_ok = 1'b0;
            if (done) begin done_at = n; break; end
        end
        check(nwr == np, "R9", {req, " write count"}, 64'(nwr), 64'(np));
        check(order_ok, "R9", {req, " writes on consecutive cycles"}, 64'(order_ok), 64'd1);
        check(done_at == np + 1, "R10", {req, " done cycle"}, 64'(done_at), 64'(np + 1));
        @(negedge clk);
        check(!done && !busy, "R10", {req, " done single pulse, idle"}, {done, busy}, 64'd0);
        for (int i = 0; i < 32; i++)
            check(rf[i] === exp_rf[i], req, $sformatf("register %0d", i), rf[i], exp_rf[i]);
    endtask

    task automatic t_reset;
        check(!wr_en && !done && !busy, "R1", "reset outputs", {wr_en, done, busy}, 64'd0);
    endtask

    task automatic t_case_inverted;
        for (int i = 0; i < 32; i++) rf[i] = '0;
        rf[3] = 64'b101; rf[9] = 64'h90; rf[10] = 64'h91; rf[11] = 64'h92;
        run_case("R2 R3 R6", 3, 64'b101, 1'b0, 64'b101, 1'b1, 5'd9, 5'd5);
        check(rf[6] == 64'hFFFF_FFFF_FFFF_FF90, "R4", "dst elem 1", rf[6], 64'hFFFF_FFFF_FFFF_FF90);
        check(rf[5] == 0 && rf[7] == 0, "R6", "skipped slots", rf[5] | rf[7], 64'd0);
    endtask

    task automatic t_dense;
        fill_rf(64'h0);
        rf[0] = 64'h7F; rf[1] = 64'h80; rf[2] = 64'hFF; rf[3] = 64'h1234_5600;
        run_case("R3 R4", 8, '1, 1'b0, '1, 1'b0, 5'd0, 5'd16);
        check(rf[17] == 64'hFFFF_FFFF_FFFF_FF80, "R4", "bit7 set extends", rf[17], 64'hFFFF_FFFF_FFFF_FF80);
        check(rf[16] == 64'h7F, "R4", "bit7 clear extends", rf[16], 64'h7F);
    endtask

    task automatic t_sparse;
        fill_rf(64'hA5A5_0000_1111_2222);
        run_case("R3 R7", 64, 64'h8001_0000_0421_0013, 1'b0,
                 64'h0F00_0030_0000_8C00, 1'b0, 5'd2, 5'd0);
    endtask

    task automatic t_src_short;
        fill_rf(64'h5555_1234_0000_00C3);
        run_case("R7", 12, 64'h0000_0000_0000_0400, 1'b0, 64'h0FFF, 1'b0, 5'd0, 5'd20);
    endtask

    task automatic t_dst_short;
        fill_rf(64'h0BAD_F00D_0000_0081);
        run_case("R7 R6", 10, 64'h3FF, 1'b0, 64'h200, 1'b0, 5'd0, 5'd12);
    endtask

    task automatic t_vl_cut;
        fill_rf(64'h1357_9BDF_2468_ACE0);
        run_case("R8", 5, '1, 1'b0, '1, 1'b0, 5'd0, 5'd8);
    endtask

    task automatic t_vl_zero;
        fill_rf(64'hDEAD_BEEF_0000_0000);
        run_case("R8", 0, '1, 1'b0, '1, 1'b0, 5'd0, 5'd1);
    endtask

    task automatic t_wrap;
        fill_rf(64'h0F0F_0F0F_0000_0077);
        run_case("R5", 6, 64'b111111, 1'b0, 64'b000000, 1'b1, 5'd30, 5'd29);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) rf[i] = '0;
        #1;
        t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_case_inverted();
        t_dense();
        t_sparse();
        t_src_short();
        t_dst_short();
        t_vl_cut();
        t_vl_zero();
        t_wrap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule